// File: doc/BRIEF.md
# Regulator ADC Offset Calibration Sequencer

This block runs on the controller side. It calibrates the voltage ADC of an attached power stage before regulation begins. It talks to the power devices through a simple request port. A request stays up until the device acknowledges it, and a read returns its data with the acknowledge.

When started, the block first reads the status register of every device, lowest device number first. It goes on only if every device reports a clean status. It then copies the external voltage setpoint into the setpoint register of device 1, which is the device wired for regulation, and writes calibration mode to that device. The device returns its ADC offset as eight serial bits on an error line. The block stores the offset through a one-cycle store strobe, writes normal mode back to device 1, and reports completion.

A missing acknowledge ends the sequence in a frozen fault state. So does a non-zero status read, or a fault indication seen once calibration has begun. In that state a fault-handling request is raised and the stage where the sequence stopped is kept. Only a reset leaves this state.

Top module: `cal_sequencer`

## Requirements
- R1: After reset, busy, done, fault_req, req_valid and st_valid are all low.
- R2: A start in the idle state launches status reads at register address 2 of devices 1 to N_DEV, in increasing order. A non-zero value read from any of them is a fault. Bit 0 of that value is the input under-voltage lockout flag, and bits 7:1 are the other fault flags. Reads stop at the failing device.
- R3: After every status read returns zero, the block writes the value on vid_ext to register address 3 of device 1.
- R4: Once the setpoint write is acknowledged, the block writes 0x01 (calibration mode) to register address 4 of device 1.
- R5: After the calibration-mode write is acknowledged, the block takes 8 bits from err_data, one at each rising edge of err_clk as seen at clk. The first bit taken is the most significant bit of the offset.
- R6: In the cycle after the eighth bit is taken, st_valid is high for exactly one cycle with the offset on st_data. In the next cycle the block writes 0x00 (normal mode) to register address 4 of device 1. Once that write is acknowledged, done is high.
- R7: A request that has not been acknowledged by the 256th clock edge after it was raised ends in the fault state. An acknowledge seen at the 256th edge is still accepted.
- R8: In the fault state, fault_req stays high, start is ignored and fault_stage holds the stage where the fault occurred until reset. Stage codes: 1 status polling, 2 setpoint write, 3 calibration-mode write, 4 serial capture, 5 store, 6 normal-mode write, 7 done.
- R9: fault_in is acted on only from the calibration-mode write up to and including done, and there it sends the block to the fault state at the next edge. In those stages it wins over a coinciding acknowledge, and in the store cycle it suppresses st_valid. During status polling and the setpoint write it is ignored.
- R10: A start pulse while busy is ignored. A start pulse while done begins a fresh sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request |
| vid_ext | input | 8 | External voltage setpoint |
| fault_in | input | 1 | Live fault indication |
| req_valid | output | 1 | Register request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_dev | output | 3 | Target device number |
| req_addr | output | 4 | Target register address |
| req_wdata | output | 8 | Write data |
| resp_ack | input | 1 | Request acknowledge |
| resp_rdata | input | 8 | Read data, valid with acknowledge |
| err_clk | input | 1 | Serial error clock |
| err_data | input | 1 | Serial error data |
| st_valid | output | 1 | Offset store strobe |
| st_data | output | 8 | Offset value to store |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Calibration complete |
| fault_req | output | 1 | Fault handling requested |
| fault_stage | output | 4 | Stage at which the fault occurred |

## Verification
The pairs that matter are a fault indication landing in the same cycle as a step of the sequence itself. One such pair is fault_in together with the acknowledge of the normal-mode write. The other is fault_in inside the single store cycle. The bench raises fault_in in exactly the cycle that the device model acknowledges the final write. It expects stage 6 with done never rising. It also raises fault_in between the edge that enters the store stage and the following edge. There it expects no store strobe and stage 5. The same injection on the setpoint-write acknowledge must be ignored, because calibration has not yet begun.

// File: rtl/cal_sequencer.sv
`timescale 1ns/1ps
module cal_sequencer #(
  parameter int N_DEV       = 4,
  parameter int DW          = 8,
  parameter int ADDR_W      = 4,
  parameter int STAT_ADDR   = 2,
  parameter int VID_ADDR    = 3,
  parameter int MODE_ADDR   = 4,
  parameter int MODE_CAL    = 1,
  parameter int MODE_NORMAL = 0,
  parameter int CAL_DEV     = 1,
  parameter int TIMEOUT     = 256,
  parameter int DEV_W       = $clog2(N_DEV + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DW-1:0]     vid_ext,
  input  logic              fault_in,
  output logic              req_valid,
  output logic              req_write,
  output logic [DEV_W-1:0]  req_dev,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DW-1:0]     req_wdata,
  input  logic              resp_ack,
  input  logic [DW-1:0]     resp_rdata,
  input  logic              err_clk,
  input  logic              err_data,
  output logic              st_valid,
  output logic [DW-1:0]     st_data,
  output logic              busy,
  output logic              done,
  output logic              fault_req,
  output logic [3:0]        fault_stage
);
  localparam int TW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam int BW = $clog2(DW);
  localparam logic [TW-1:0]     T_LAST = TW'(TIMEOUT - 1);
  localparam logic [BW-1:0]     B_LAST = BW'(DW - 1);
  localparam logic [DEV_W-1:0]  D_LAST = DEV_W'(N_DEV);
  localparam logic [DEV_W-1:0]  D_CAL  = DEV_W'(CAL_DEV);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_VID  = ADDR_W'(VID_ADDR);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(MODE_ADDR);
  localparam logic [DW-1:0]     M_CAL  = DW'(MODE_CAL);
  localparam logic [DW-1:0]     M_NORM = DW'(MODE_NORMAL);

  typedef enum logic [3:0] {
    S_IDLE = 4'd0, S_POLL = 4'd1, S_VID = 4'd2, S_CAL = 4'd3, S_SHIFT = 4'd4,
    S_STORE = 4'd5, S_NORM = 4'd6, S_DONE = 4'd7, S_FAULT = 4'd8
  } st_t;

  st_t st, nx;
  logic [DEV_W-1:0] dev;
  logic [TW-1:0]    wcnt;
  logic [BW-1:0]    bcnt;
  logic [DW-1:0]    sr;
  logic             err_q;
  logic [3:0]       stage_q;

  wire err_rise = err_clk & ~err_q;
  wire in_cal   = st inside {S_CAL, S_SHIFT, S_STORE, S_NORM, S_DONE};
  wire tmo      = req_valid && !resp_ack && (wcnt == T_LAST);

  assign req_valid = st inside {S_POLL, S_VID, S_CAL, S_NORM};
  assign req_write = req_valid && (st != S_POLL);
  assign req_dev   = (st == S_POLL) ? dev : D_CAL;

  always_comb begin
    req_addr  = '0;
    req_wdata = '0;
    case (st)
      S_POLL: req_addr = A_STAT;
      S_VID:  begin req_addr = A_VID;  req_wdata = vid_ext; end
      S_CAL:  begin req_addr = A_MODE; req_wdata = M_CAL;   end
      S_NORM: begin req_addr = A_MODE; req_wdata = M_NORM;  end
      default: ;
    endcase
  end

  always_comb begin
    nx = st;
    if (in_cal && fault_in) nx = S_FAULT;
    else if (tmo) nx = S_FAULT;
    else begin
      case (st)
        S_IDLE:  if (start) nx = S_POLL;
        S_POLL:  if (resp_ack) begin
                   if (resp_rdata != '0) nx = S_FAULT;
                   else if (dev == D_LAST) nx = S_VID;
                 end
        S_VID:   if (resp_ack) nx = S_CAL;
        S_CAL:   if (resp_ack) nx = S_SHIFT;
        S_SHIFT: if (err_rise && bcnt == B_LAST) nx = S_STORE;
        S_STORE: nx = S_NORM;
        S_NORM:  if (resp_ack) nx = S_DONE;
        S_DONE:  if (start) nx = S_POLL;
        default: nx = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      dev     <= '0;
      wcnt    <= '0;
      bcnt    <= '0;
      sr      <= '0;
      err_q   <= 1'b0;
      stage_q <= '0;
    end else begin
      st    <= nx;
      err_q <= err_clk;
      if (nx == S_FAULT && st != S_FAULT) stage_q <= st;
      if (!req_valid || resp_ack) wcnt <= '0;
      else wcnt <= wcnt + 1'b1;
      if (st == S_IDLE || st == S_DONE) dev <= DEV_W'(1);
      else if (st == S_POLL && resp_ack) dev <= dev + 1'b1;
      if (st != S_SHIFT) bcnt <= '0;
      else if (err_rise) bcnt <= bcnt + 1'b1;
      if (st == S_SHIFT && err_rise) sr <= {sr[DW-2:0], err_data};
    end
  end

  assign st_valid    = (st == S_STORE) && !fault_in;
  assign st_data     = sr;
  assign busy        = !(st inside {S_IDLE, S_DONE, S_FAULT});
  assign done        = (st == S_DONE);
  assign fault_req   = (st == S_FAULT);
  assign fault_stage = stage_q;

  assert_flags_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done, fault_req}));

  assert_store_then_normal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> (req_valid && req_write && req_addr == A_MODE && req_wdata == M_NORM));

  assert_done_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(req_valid && resp_ack));

  assert_timeout_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !resp_ack && wcnt == T_LAST) |=> fault_req);

  assert_fault_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req |=> (fault_req && $stable(fault_stage)));

  assert_cal_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((done || st_valid || (req_valid && req_write && req_addr == A_MODE)) && fault_in) |=> fault_req);
endmodule

// File: tb/test_cal_sequencer.sv
`timescale 1ns/1ps
module test_cal_sequencer;
  localparam int N = 4;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, err_clk = 1'b0, err_data = 1'b0;
  logic [7:0] vid_ext = 8'h0;
  logic fault_hold = 1'b0, fault_pulse = 1'b0;
  wire  fault_in = fault_hold | fault_pulse;
  logic req_valid, req_write, st_valid, busy, done, fault_req;
  logic [2:0] req_dev;
  logic [3:0] req_addr, fault_stage;
  logic [7:0] req_wdata, st_data;
  logic resp_ack = 1'b0;
  logic [7:0] resp_rdata = 8'h0;

  cal_sequencer i_cal_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .vid_ext(vid_ext), .fault_in(fault_in),
    .req_valid(req_valid), .req_write(req_write), .req_dev(req_dev), .req_addr(req_addr),
    .req_wdata(req_wdata), .resp_ack(resp_ack), .resp_rdata(resp_rdata),
    .err_clk(err_clk), .err_data(err_data), .st_valid(st_valid), .st_data(st_data),
    .busy(busy), .done(done), .fault_req(fault_req), .fault_stage(fault_stage));

  int checks = 0, failures = 0, cyc = 0;
  int lat = 0, stall_idx = -1, inj_req = -1;
  int req_num = 0, cnt = 0, lg_n = 0, base = 0;
  logic [7:0] status [1:N];
  int lg_kind [0:63], lg_dev [0:63], lg_addr [0:63], lg_data [0:63];

  // device model: owns resp_ack, resp_rdata, fault_pulse and the log
  always @(negedge clk) begin
    cyc++;
    if (fault_pulse) fault_pulse = 1'b0;
    if (!rst_n) begin
      resp_ack = 1'b0; cnt = 0; req_num = 0;
    end else begin
      if (st_valid) begin
        lg_kind[lg_n % 64] = 2; lg_dev[lg_n % 64] = 0;
        lg_addr[lg_n % 64] = 0; lg_data[lg_n % 64] = int'(st_data); lg_n++;
      end
      if (resp_ack) begin resp_ack = 1'b0; cnt = 0; req_num++; end
      if (req_valid) begin
        if (req_num != stall_idx && cnt >= lat) begin
          resp_ack   = 1'b1;
          resp_rdata = req_write ? 8'h00 : status[int'(req_dev)];
          lg_kind[lg_n % 64] = req_write ? 1 : 0; lg_dev[lg_n % 64] = int'(req_dev);
          lg_addr[lg_n % 64] = int'(req_addr); lg_data[lg_n % 64] = int'(req_wdata); lg_n++;
          if (req_num == inj_req) fault_pulse = 1'b1;
        end else cnt++;
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(negedge clk) if (cyc == 190000) begin
    failures++;
    $display("FAIL watchdog act=%0d exp=<190000", cyc);
    summary();
    $finish;
  end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; err_clk = 1'b0; err_data = 1'b0; fault_hold = 1'b0;
    lat = 0; stall_idx = -1; inj_req = -1;
    for (int d = 1; d <= N; d++) status[d] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // fmode: 0 plain, 1 fault after 3 bits, 2 fault in store cycle, 3 fault after done, 4 second start while busy
  task automatic go(input int ofs, input int vid, input int fmode);
    int w;
    base = lg_n; vid_ext = vid[7:0];
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (fmode == 4) begin
      repeat (2) @(negedge clk);
      chk("R10 busy during poll", int'(busy), 1);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    w = 0;
    while (lg_n < base + 6 && !fault_req && w < 2000) begin @(negedge clk); w++; end
    if (!fault_req && lg_n >= base + 6) begin
      repeat (2) @(negedge clk);
      for (int i = 7; i >= 0; i--) begin
        if (!(fmode == 1 && i < 5)) begin
          @(negedge clk); err_data = ofs[i]; err_clk = 1'b1;
          if (i == 0 && fmode == 2) begin @(posedge clk); #1 fault_hold = 1'b1; end
          @(negedge clk); err_clk = 1'b0;
        end
      end
      if (fmode == 1) fault_hold = 1'b1;
    end
    w = 0;
    while (!done && !fault_req && w < 600) begin @(negedge clk); w++; end
    if (fmode == 3 && done) begin
      @(negedge clk) fault_hold = 1'b1;
      repeat (2) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic check_full(input int ofs, input int vid);
    int e;
    e = 0;
    for (int i = 0; i < N; i++)
      if (lg_kind[(base+i)%64] != 0 || lg_dev[(base+i)%64] != i + 1 || lg_addr[(base+i)%64] != 2) e++;
    chk("R2 status reads in order", e, 0);
    e = (lg_kind[(base+N)%64] == 1 && lg_dev[(base+N)%64] == 1 && lg_addr[(base+N)%64] == 3) ? lg_data[(base+N)%64] : -1;
    chk("R3 setpoint write", e, vid);
    e = (lg_kind[(base+N+1)%64] == 1 && lg_dev[(base+N+1)%64] == 1 && lg_addr[(base+N+1)%64] == 4) ? lg_data[(base+N+1)%64] : -1;
    chk("R4 cal mode write", e, 1);
    e = (lg_kind[(base+N+2)%64] == 2) ? lg_data[(base+N+2)%64] : -1;
    chk("R5 captured offset", e, ofs);
    e = (lg_kind[(base+N+3)%64] == 1 && lg_addr[(base+N+3)%64] == 4) ? lg_data[(base+N+3)%64] : -1;
    chk("R6 normal write after store", e, 0);
    chk("R6 entry count", lg_n - base, N + 4);
    chk("R6 done", int'(done), 1);
  endtask

  initial begin
    do_reset();
    chk("R1 reset flags", int'({busy, done, fault_req, req_valid, st_valid}), 0);

    // every offset value; restart from done each time (R10)
    for (int v = 0; v < 256; v++) begin
      lat = v % 4;
      go(v, v ^ 8'h5A, 0);
      check_full(v, v ^ 8'h5A);
    end

    // second start while busy is ignored (R10)
    do_reset(); lat = 3;
    go(8'hC3, 8'h11, 4);
    check_full(8'hC3, 8'h11);

    // status faults on every device and flag bit (R2, R8)
    for (int k = 1; k <= N; k++)
      for (int b = 0; b < 8; b++) begin
        do_reset();
        status[k] = 8'(1 << b);
        go(0, 0, 0);
        chk("R2 status fault", int'(fault_req), 1);
        chk("R8 stage poll", int'(fault_stage), 1);
        chk("R2 reads up to failing device", lg_n - base, k);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 start ignored in fault", int'(fault_req) * 16 + int'(fault_stage), 16 + 1);
        chk("R8 no request after fault", lg_n - base, k);
      end

    // acknowledge at the last allowed edge (R7)
    do_reset(); lat = 255;
    go(8'h96, 8'h42, 0);
    check_full(8'h96, 8'h42);
    do_reset(); lat = 256;
    go(8'h96, 8'h42, 0);
    chk("R7 one edge too late", int'(fault_req) * 16 + int'(fault_stage), 16 + 1);

    // no acknowledge on each request in turn (R7)
    for (int s = 0; s < 7; s++) begin
      do_reset(); stall_idx = s;
      go(8'h3C, 8'h20, 0);
      chk("R7 timeout stage", int'(fault_req) * 16 + int'(fault_stage),
          16 + ((s < 4) ? 1 : (s == 4) ? 2 : (s == 5) ? 3 : 6));
    end

    // fault_in ignored in poll and setpoint stages (R9)
    do_reset(); inj_req = 0;
    go(8'hA5, 8'h33, 0);
    chk("R9 ignored during poll", int'(done) * 2 + int'(fault_req), 2);
    do_reset(); inj_req = 4;
    go(8'hA5, 8'h33, 0);
    chk("R9 ignored on setpoint ack", int'(done) * 2 + int'(fault_req), 2);

    // fault_in with cal-mode ack and with normal-mode ack (R9)
    do_reset(); inj_req = 5;
    go(8'h5A, 8'h33, 0);
    chk("R9 fault at cal ack", int'(fault_req) * 16 + int'(fault_stage), 16 + 3);
    do_reset(); inj_req = 6;
    go(8'h5A, 8'h33, 0);
    chk("R9 fault beats normal ack", int'(fault_req) * 16 + int'(fault_stage), 16 + 6);
    chk("R9 no done", int'(done), 0);
    chk("R9 store already made", (lg_kind[(base+6)%64] == 2) ? lg_data[(base+6)%64] : -1, 8'h5A);

    // fault_in during capture, in store cycle, after done (R9)
    do_reset();
    go(8'hFF, 8'h01, 1);
    chk("R9 fault during capture", int'(fault_req) * 16 + int'(fault_stage), 16 + 4);
    do_reset();
    go(8'h81, 8'h01, 2);
    chk("R9 fault in store cycle", int'(fault_req) * 16 + int'(fault_stage), 16 + 5);
    chk("R9 store suppressed", lg_n - base, 6);
    do_reset();
    go(8'h7E, 8'h01, 3);
    chk("R9 fault after done", int'(fault_req) * 16 + int'(fault_stage), 16 + 7);
    chk("R8 done cleared by fault", int'(done), 0);

    summary();
    $finish;
  end
endmodule